// File: doc/BRIEF.md
# Package Idle-State Controller

This block decides how deeply a multi-core package may sleep and then steps the package into and out of that sleep level. Each core reports the idle level it wants. The block takes the shallowest of these levels. It checks that the graphics engine is idle. It then lowers the level for the platform's latency tolerance and for a pending timer event. The result is a target package state.

A sequencer moves the package toward that target:

- The package leaves the active state through the shallow C2 state.
- Every deep state is entered and left through the transitional state C2R.
- The sequencer waits for a power or flush acknowledge before it reports that a deep state has been reached.

Break events change the path:

- An unmasked core interrupt returns the package to active and sends a wake pulse to the core it targets.
- A masked interrupt re-enters the deep state the package held before the event.
- Memory or snoop traffic parks the package in C2 until the traffic drains.
- A platform request to stay shallow holds the package in C2.

The latency threshold for each deep state is held in a register and written through a small write port.

Top module: `pkg_idle_ctrl`

## Requirements
- R1: A synchronous reset sets the following, and resets every latency threshold to 0:
  - `pkg_state` is 0 (C0);
  - `in_c2r`, `flush_full`, `flush_inc`, `deep_idle` and `core_wake` are all low.
- R2: Package and core codes are 0=C0, 1=C2, 2=C3, 3=C6, 4=C7, 5=C7S, 6=C8, 7=C10; code 8 is the transitional state C2R. Each core requests a 3-bit code in `core_req[3*c+2:3*c]`. Only the smallest code among the cores counts. If that code is below 3, or `gfx_idle` is low, the target is C0.
- R3: When the smallest request is 3 or more and `gfx_idle` is high, the target is picked as follows:
  - If `timer_near` is high, the target is C2.
  - Otherwise the target is the deepest state whose code is at most the smallest request and whose threshold is at most `ltr_val`.
  - If no state qualifies, the target is C2.
- R4: From C0 with a nonzero target, the package first moves to C2. Every entry into code 2..7 comes from C2R. Every exit from code 2..7 goes to C2R.
- R5: During an entry the package holds C2R until `pwr_ack` is sampled high. On the cycle after that, `pkg_state` shows the target.
- R6: While entering C7S, C8 or C10, `flush_full` is high. While entering C7, `flush_inc` is high. Both are low at all other times.
- R7: An unmasked break (`brk_valid` high, `brk_masked` low) does two things:
  - It pulses bit `brk_core` of `core_wake` for one cycle.
  - It sends the package to C0. From a deep state it goes through one cycle of C2R.
- R8: A masked break in a deep state sends the package to C2R. The package then re-enters the same deep state on `pwr_ack`.
- R9: When `mem_busy` is high in a deep state, the package takes one cycle of C2R and then sits in C2 while `mem_busy` stays high. When the traffic ends, the package re-enters its previous deep state.
- R10: While `hold_shallow` is high, a package in C2 stays in C2. This applies both after memory traffic and on a normal entry.
- R11: During an entry, `mem_busy` or a masked break aborts the entry to C2, and an unmasked break aborts it to C0.
- R12: `deep_idle` is high exactly while `pkg_state` is 7 (C10). `in_c2r` is high exactly while `pkg_state` is 8.
- R13: A write with `cfg_we` high and `cfg_addr` set to a code from 2 to 7 loads that state's threshold. The new value applies from the next cycle. When the target changes while the package is in a deep state, the package leaves through C2R and C2 and then re-resolves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_req | input | 3*N_CORES | Idle code requested by each core |
| gfx_idle | input | 1 | Graphics engine is idle |
| ltr_val | input | LTR_W | Platform latency tolerance |
| timer_near | input | 1 | A timer event is imminent |
| brk_valid | input | 1 | Core break event this cycle |
| brk_masked | input | 1 | The break event is masked |
| brk_core | input | CID_W | Core targeted by the break |
| mem_busy | input | 1 | Memory or snoop traffic outstanding |
| hold_shallow | input | 1 | Platform asks to stay in C2 |
| pwr_ack | input | 1 | Flush and power acknowledge for the entry |
| cfg_we | input | 1 | Threshold write strobe |
| cfg_addr | input | 3 | State code of the threshold to write |
| cfg_wdata | input | LTR_W | Threshold value |
| pkg_state | output | 4 | Current package state code |
| in_c2r | output | 1 | Package is in the transitional state |
| flush_full | output | 1 | Single-step full cache flush request |
| flush_inc | output | 1 | Incremental cache flush request |
| deep_idle | output | 1 | Package is in C10 |
| core_wake | output | N_CORES | One-cycle wake pulse per core |

## Verification
The bench targets the following cases:

- **Demotion.** Latency tolerance is set between thresholds, so a design that ignores the limits jumps straight to C10 instead of C7S or C3.
- **Re-entry.** Masked breaks and finished memory traffic must return to the saved deep state. A design that loses this state ends up in C0 or in the wrong level.
- **Aborted entries.** Memory traffic and unmasked breaks arrive mid-entry. A design that keeps waiting for the acknowledge would wrongly report the deep state.
- **Holds and resolution.** `hold_shallow`, a near timer, one awake core and busy graphics each keep the package shallow. A design that resolves on the deepest core rather than the shallowest fails here.

// File: rtl/pkg_idle_pkg.sv
package pkg_idle_pkg;
  localparam int REQ_W    = 3;
  localparam int STATE_W  = 4;
  localparam int THR_BASE = 2;
  localparam int N_THR    = 6;

  typedef enum logic [STATE_W-1:0] {
    PS_C0  = 4'd0,
    PS_C2  = 4'd1,
    PS_C3  = 4'd2,
    PS_C6  = 4'd3,
    PS_C7  = 4'd4,
    PS_C7S = 4'd5,
    PS_C8  = 4'd6,
    PS_C10 = 4'd7,
    PS_C2R = 4'd8
  } pstate_t;

  typedef enum logic [2:0] {
    M_ACT,
    M_SHAL,
    M_ENT,
    M_DEEP,
    M_EXIT,
    M_MEM
  } mode_t;
endpackage

// File: rtl/pkg_idle_min_req.sv
module pkg_idle_min_req
  import pkg_idle_pkg::*;
#(
  parameter int N_CORES = 4
) (
  input  logic [REQ_W*N_CORES-1:0] core_req,
  input  logic                     gfx_idle,
  output logic [REQ_W-1:0]         min_req,
  output logic                     deep_ok
);
  // shallowest request across all cores
  always_comb begin
    min_req = '1;
    for (int c = 0; c < N_CORES; c++) begin
      if (core_req[c*REQ_W +: REQ_W] < min_req)
        min_req = core_req[c*REQ_W +: REQ_W];
    end
  end

  // deep package states need every core at C6 or deeper
  assign deep_ok = gfx_idle && (min_req >= REQ_W'(PS_C6));
endmodule

// File: rtl/pkg_idle_thr.sv
module pkg_idle_thr
  import pkg_idle_pkg::*;
#(
  parameter int LTR_W = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cfg_we,
  input  logic [2:0]             cfg_addr,
  input  logic [LTR_W-1:0]       cfg_wdata,
  output logic [N_THR*LTR_W-1:0] thr_flat
);
  for (genvar s = 0; s < N_THR; s++) begin : g_thr
    logic [LTR_W-1:0] thr_q;

    always_ff @(posedge clk) begin
      if (rst)
        thr_q <= '0;
      else if (cfg_we && cfg_addr == 3'(s + THR_BASE))
        thr_q <= cfg_wdata;
    end

    assign thr_flat[s*LTR_W +: LTR_W] = thr_q;
  end
endmodule

// File: rtl/pkg_idle_demote.sv
module pkg_idle_demote
  import pkg_idle_pkg::*;
#(
  parameter int LTR_W = 8
) (
  input  logic [REQ_W-1:0]       min_req,
  input  logic                   deep_ok,
  input  logic                   timer_near,
  input  logic [LTR_W-1:0]       ltr_val,
  input  logic [N_THR*LTR_W-1:0] thr_flat,
  output pstate_t                target
);
  // deepest state allowed by both the request and the latency tolerance
  always_comb begin
    target = PS_C0;
    if (deep_ok) begin
      target = PS_C2;
      if (!timer_near) begin
        for (int i = 0; i < N_THR; i++) begin
          if ((i + THR_BASE) <= int'(min_req) &&
              ltr_val >= thr_flat[i*LTR_W +: LTR_W])
            target = pstate_t'(STATE_W'(i + THR_BASE));
        end
      end
    end
  end
endmodule

// File: rtl/pkg_idle_seq.sv
module pkg_idle_seq
  import pkg_idle_pkg::*;
#(
  parameter int N_CORES = 4,
  parameter int CID_W   = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  pstate_t            target,
  input  logic               brk_valid,
  input  logic               brk_masked,
  input  logic [CID_W-1:0]   brk_core,
  input  logic               mem_busy,
  input  logic               hold_shallow,
  input  logic               pwr_ack,
  output logic [STATE_W-1:0] pkg_state,
  output logic               in_c2r,
  output logic               flush_full,
  output logic               flush_inc,
  output logic               deep_idle,
  output logic [N_CORES-1:0] core_wake
);
  mode_t   mode_q, mode_d, dest_q, dest_d;
  pstate_t ent_q, ent_d, prev_q, prev_d;
  logic    wake_u, wake_m;
  logic [N_CORES-1:0] wake_vec;

  assign wake_u = brk_valid && !brk_masked;
  assign wake_m = brk_valid && brk_masked;

  always_comb begin
    for (int c = 0; c < N_CORES; c++)
      wake_vec[c] = wake_u && (brk_core == CID_W'(c));
  end

  function automatic pstate_t st_of(mode_t m, pstate_t p);
    case (m)
      M_ACT:          return PS_C0;
      M_SHAL, M_MEM:  return PS_C2;
      M_ENT, M_EXIT:  return PS_C2R;
      default:        return p;
    endcase
  endfunction

  always_comb begin
    mode_d = mode_q;
    dest_d = dest_q;
    ent_d  = ent_q;
    prev_d = prev_q;
    case (mode_q)
      M_ACT: begin
        if (target != PS_C0 && !wake_u) mode_d = M_SHAL;
      end
      M_SHAL: begin
        if (wake_u || target == PS_C0) begin
          mode_d = M_ACT;
        end else if (!mem_busy && !hold_shallow && target != PS_C2) begin
          mode_d = M_ENT;
          ent_d  = target;
        end
      end
      M_ENT: begin
        if (wake_u)                   mode_d = M_ACT;
        else if (mem_busy || wake_m)  mode_d = M_SHAL;
        else if (pwr_ack) begin
          mode_d = M_DEEP;
          prev_d = ent_q;
        end
      end
      M_DEEP: begin
        if (wake_u) begin
          mode_d = M_EXIT;
          dest_d = M_ACT;
        end else if (mem_busy) begin
          mode_d = M_EXIT;
          dest_d = M_MEM;
        end else if (wake_m) begin
          mode_d = M_ENT;
          ent_d  = prev_q;
        end else if (target != prev_q) begin
          mode_d = M_EXIT;
          dest_d = M_SHAL;
        end
      end
      M_EXIT: mode_d = dest_q;
      M_MEM: begin
        if (wake_u)            mode_d = M_ACT;
        else if (mem_busy)     mode_d = M_MEM;
        else if (hold_shallow) mode_d = M_SHAL;
        else begin
          mode_d = M_ENT;
          ent_d  = prev_q;
        end
      end
      default: mode_d = M_ACT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q     <= M_ACT;
      dest_q     <= M_ACT;
      ent_q      <= PS_C0;
      prev_q     <= PS_C0;
      pkg_state  <= PS_C0;
      in_c2r     <= 1'b0;
      flush_full <= 1'b0;
      flush_inc  <= 1'b0;
      deep_idle  <= 1'b0;
      core_wake  <= '0;
    end else begin
      mode_q     <= mode_d;
      dest_q     <= dest_d;
      ent_q      <= ent_d;
      prev_q     <= prev_d;
      pkg_state  <= st_of(mode_d, prev_d);
      in_c2r     <= (mode_d == M_ENT) || (mode_d == M_EXIT);
      flush_full <= (mode_d == M_ENT) &&
                    (ent_d == PS_C7S || ent_d == PS_C8 || ent_d == PS_C10);
      flush_inc  <= (mode_d == M_ENT) && (ent_d == PS_C7);
      deep_idle  <= (mode_d == M_DEEP) && (prev_d == PS_C10);
      core_wake  <= wake_vec;
    end
  end
endmodule

// File: rtl/pkg_idle_ctrl.sv
module pkg_idle_ctrl
  import pkg_idle_pkg::*;
#(
  parameter int N_CORES = 4,
  parameter int LTR_W   = 8,
  parameter int CID_W   = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [REQ_W*N_CORES-1:0] core_req,
  input  logic                     gfx_idle,
  input  logic [LTR_W-1:0]         ltr_val,
  input  logic                     timer_near,
  input  logic                     brk_valid,
  input  logic                     brk_masked,
  input  logic [CID_W-1:0]         brk_core,
  input  logic                     mem_busy,
  input  logic                     hold_shallow,
  input  logic                     pwr_ack,
  input  logic                     cfg_we,
  input  logic [2:0]               cfg_addr,
  input  logic [LTR_W-1:0]         cfg_wdata,
  output logic [STATE_W-1:0]       pkg_state,
  output logic                     in_c2r,
  output logic                     flush_full,
  output logic                     flush_inc,
  output logic                     deep_idle,
  output logic [N_CORES-1:0]       core_wake
);
  logic [REQ_W-1:0]       min_req;
  logic                   deep_ok;
  logic [N_THR*LTR_W-1:0] thr_flat;
  pstate_t                target;

  pkg_idle_min_req #(.N_CORES(N_CORES)) u_min (
    .core_req (core_req),
    .gfx_idle (gfx_idle),
    .min_req  (min_req),
    .deep_ok  (deep_ok)
  );

  pkg_idle_thr #(.LTR_W(LTR_W)) u_thr (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .thr_flat  (thr_flat)
  );

  pkg_idle_demote #(.LTR_W(LTR_W)) u_dem (
    .min_req    (min_req),
    .deep_ok    (deep_ok),
    .timer_near (timer_near),
    .ltr_val    (ltr_val),
    .thr_flat   (thr_flat),
    .target     (target)
  );

  pkg_idle_seq #(.N_CORES(N_CORES), .CID_W(CID_W)) u_seq (
    .clk          (clk),
    .rst          (rst),
    .target       (target),
    .brk_valid    (brk_valid),
    .brk_masked   (brk_masked),
    .brk_core     (brk_core),
    .mem_busy     (mem_busy),
    .hold_shallow (hold_shallow),
    .pwr_ack      (pwr_ack),
    .pkg_state    (pkg_state),
    .in_c2r       (in_c2r),
    .flush_full   (flush_full),
    .flush_inc    (flush_inc),
    .deep_idle    (deep_idle),
    .core_wake    (core_wake)
  );
endmodule

// File: rtl/pkg_idle_chk.sv
module pkg_idle_chk #(
  parameter int N_CORES = 4
) (
  input logic               clk,
  input logic               rst,
  input logic [3:0]         pkg_state,
  input logic               in_c2r,
  input logic               flush_full,
  input logic               flush_inc,
  input logic               deep_idle,
  input logic [N_CORES-1:0] core_wake,
  input logic               brk_valid,
  input logic               brk_masked
);
  localparam logic [3:0] S_C0  = 4'd0;
  localparam logic [3:0] S_C2  = 4'd1;
  localparam logic [3:0] S_C10 = 4'd7;
  localparam logic [3:0] S_C2R = 4'd8;

  function automatic logic is_deep(logic [3:0] s);
    return (s >= 4'd2) && (s <= 4'd7);
  endfunction

  assert_leave_c0_via_c2_R4: assert property (@(posedge clk) disable iff (rst)
    (pkg_state == S_C0) |=> (pkg_state == S_C0 || pkg_state == S_C2));

  assert_deep_entry_from_c2r_R4: assert property (@(posedge clk) disable iff (rst)
    (is_deep(pkg_state) && pkg_state != $past(pkg_state)) |-> ($past(pkg_state) == S_C2R));

  assert_deep_exit_to_c2r_R4: assert property (@(posedge clk) disable iff (rst)
    is_deep(pkg_state) |=> (pkg_state == $past(pkg_state) || pkg_state == S_C2R));

  assert_wake_leaves_deep_R7: assert property (@(posedge clk) disable iff (rst)
    (brk_valid && !brk_masked && is_deep(pkg_state)) |=> (pkg_state == S_C2R));

  assert_wake_onehot_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(core_wake));

  assert_flush_in_entry_R6: assert property (@(posedge clk) disable iff (rst)
    (flush_full || flush_inc) |-> (in_c2r && !(flush_full && flush_inc)));

  assert_deep_idle_c10_R12: assert property (@(posedge clk) disable iff (rst)
    deep_idle |-> (pkg_state == S_C10));

  assert_c2r_flag_R12: assert property (@(posedge clk) disable iff (rst)
    in_c2r == (pkg_state == S_C2R));
endmodule

bind pkg_idle_ctrl pkg_idle_chk #(.N_CORES(N_CORES)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .pkg_state  (pkg_state),
  .in_c2r     (in_c2r),
  .flush_full (flush_full),
  .flush_inc  (flush_inc),
  .deep_idle  (deep_idle),
  .core_wake  (core_wake),
  .brk_valid  (brk_valid),
  .brk_masked (brk_masked)
);

// File: tb/pkg_idle_ctrl_bench.sv
module pkg_idle_ctrl_bench;
  localparam int NC = 4;
  localparam int LW = 8;
  localparam int NV = 48;

  logic          clk = 1'b0;
  logic          rst;
  logic [11:0]   core_req;
  logic          gfx_idle, timer_near, brk_valid, brk_masked;
  logic [1:0]    brk_core;
  logic          mem_busy, hold_shallow, pwr_ack, cfg_we;
  logic [LW-1:0] ltr_val, cfg_wdata;
  logic [2:0]    cfg_addr;
  logic [3:0]    pkg_state;
  logic          in_c2r, flush_full, flush_inc, deep_idle;
  logic [NC-1:0] core_wake;
  int nchk = 0;
  int nerr = 0;

  always #2 clk = ~clk;

  pkg_idle_ctrl #(.N_CORES(NC), .LTR_W(LW)) u_pkg_idle_ctrl (
    .clk(clk), .rst(rst), .core_req(core_req), .gfx_idle(gfx_idle),
    .ltr_val(ltr_val), .timer_near(timer_near), .brk_valid(brk_valid),
    .brk_masked(brk_masked), .brk_core(brk_core), .mem_busy(mem_busy),
    .hold_shallow(hold_shallow), .pwr_ack(pwr_ack), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .pkg_state(pkg_state),
    .in_c2r(in_c2r), .flush_full(flush_full), .flush_inc(flush_inc),
    .deep_idle(deep_idle), .core_wake(core_wake)
  );

  // fields: req[32:21] ltr[20:13] {gfx,tmr,irq,msk,mem,hold,ack}[12:6] state[5:2] full[1] inc[0]
  localparam logic [32:0] VEC [NV] = '{
    {12'o0000, 8'd255, 7'b1000000, 4'd0, 2'b00},
    {12'o7777, 8'd255, 7'b1000000, 4'd1, 2'b00},
    {12'o7777, 8'd255, 7'b1000000, 4'd8, 2'b10},
    {12'o7777, 8'd255, 7'b1000000, 4'd8, 2'b10},
    {12'o7777, 8'd255, 7'b1000001, 4'd7, 2'b00},
    {12'o7777, 8'd255, 7'b1000100, 4'd8, 2'b00},
    {12'o7777, 8'd255, 7'b1000100, 4'd1, 2'b00},
    {12'o7777, 8'd255, 7'b1000100, 4'd1, 2'b00},
    {12'o7777, 8'd255, 7'b1000000, 4'd8, 2'b10},
    {12'o7777, 8'd255, 7'b1000001, 4'd7, 2'b00},
    {12'o7777, 8'd255, 7'b1011000, 4'd8, 2'b10},
    {12'o7777, 8'd255, 7'b1000001, 4'd7, 2'b00},
    {12'o7777, 8'd255, 7'b1010000, 4'd8, 2'b00},
    {12'o0000, 8'd255, 7'b1000000, 4'd0, 2'b00},
    {12'o7777, 8'd45,  7'b1000000, 4'd1, 2'b00},
    {12'o7777, 8'd45,  7'b1000000, 4'd8, 2'b10},
    {12'o7777, 8'd45,  7'b1000001, 4'd5, 2'b00},
    {12'o0000, 8'd45,  7'b1000000, 4'd8, 2'b00},
    {12'o0000, 8'd45,  7'b1000000, 4'd1, 2'b00},
    {12'o0000, 8'd45,  7'b1000000, 4'd0, 2'b00},
    {12'o4444, 8'd255, 7'b1000000, 4'd1, 2'b00},
    {12'o4444, 8'd255, 7'b1000000, 4'd8, 2'b01},
    {12'o4444, 8'd255, 7'b1000001, 4'd4, 2'b00},
    {12'o4444, 8'd15,  7'b1000000, 4'd8, 2'b00},
    {12'o4444, 8'd15,  7'b1000000, 4'd1, 2'b00},
    {12'o4444, 8'd15,  7'b1000000, 4'd8, 2'b00},
    {12'o4444, 8'd15,  7'b1000001, 4'd2, 2'b00},
    {12'o4444, 8'd15,  7'b1100000, 4'd8, 2'b00},
    {12'o4444, 8'd15,  7'b1100000, 4'd1, 2'b00},
    {12'o4444, 8'd15,  7'b1100000, 4'd1, 2'b00},
    {12'o7770, 8'd255, 7'b1000000, 4'd0, 2'b00},
    {12'o7777, 8'd255, 7'b0000000, 4'd0, 2'b00},
    {12'o7772, 8'd255, 7'b1000000, 4'd0, 2'b00},
    {12'o7777, 8'd255, 7'b1000000, 4'd1, 2'b00},
    {12'o7777, 8'd255, 7'b1000000, 4'd8, 2'b10},
    {12'o7777, 8'd255, 7'b1000100, 4'd1, 2'b00},
    {12'o7777, 8'd255, 7'b1000100, 4'd1, 2'b00},
    {12'o7777, 8'd255, 7'b1000000, 4'd8, 2'b10},
    {12'o7777, 8'd255, 7'b1010000, 4'd0, 2'b00},
    {12'o7777, 8'd255, 7'b1000000, 4'd1, 2'b00},
    {12'o7777, 8'd255, 7'b1000000, 4'd8, 2'b10},
    {12'o7777, 8'd255, 7'b1000001, 4'd7, 2'b00},
    {12'o7777, 8'd255, 7'b1000100, 4'd8, 2'b00},
    {12'o7777, 8'd255, 7'b1000100, 4'd1, 2'b00},
    {12'o7777, 8'd255, 7'b1000010, 4'd1, 2'b00},
    {12'o7777, 8'd255, 7'b1000010, 4'd1, 2'b00},
    {12'o7777, 8'd255, 7'b1000000, 4'd8, 2'b10},
    {12'o7777, 8'd255, 7'b1000001, 4'd7, 2'b00}
  };

  function automatic string tag_of(int i);
    if (i == 0)  return "R2";
    if (i <= 2)  return "R4";
    if (i <= 4)  return "R5";
    if (i <= 9)  return "R9";
    if (i <= 11) return "R8";
    if (i <= 13) return "R7";
    if (i <= 29) return "R3";
    if (i <= 32) return "R2";
    if (i <= 38) return "R11";
    return "R10";
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(logic [2:0] a, logic [LW-1:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic chk_outs(string tag, int st, bit ff, bit fi, logic [NC-1:0] wk);
    chk(tag, "pkg_state", int'(pkg_state), st);
    chk("R6", "flush_full", int'(flush_full), int'(ff));
    chk("R6", "flush_inc", int'(flush_inc), int'(fi));
    chk("R12", "in_c2r", int'(in_c2r), int'(st == 8));
    chk("R12", "deep_idle", int'(deep_idle), int'(st == 7));
    chk("R7", "core_wake", int'(core_wake), int'(wk));
  endtask

  initial begin
    #400000;
    nerr++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    rst = 1'b1; core_req = '0; gfx_idle = 1'b1; ltr_val = '0; timer_near = 1'b0;
    brk_valid = 1'b0; brk_masked = 1'b0; brk_core = 2'd2; mem_busy = 1'b0;
    hold_shallow = 1'b0; pwr_ack = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    tick(); tick();
    chk_outs("R1", 0, 1'b0, 1'b0, '0);
    rst = 1'b0;

    wr(3'd2, 8'd10); wr(3'd3, 8'd20); wr(3'd4, 8'd30);
    wr(3'd5, 8'd40); wr(3'd6, 8'd50); wr(3'd7, 8'd60);

    for (int i = 0; i < NV; i++) begin
      logic [32:0] v;
      v = VEC[i];
      core_req = v[32:21]; ltr_val = v[20:13];
      {gfx_idle, timer_near, brk_valid, brk_masked, mem_busy, hold_shallow, pwr_ack} = v[12:6];
      tick();
      chk_outs(tag_of(i), int'(v[5:2]), v[1], v[0],
               (v[10] && !v[9]) ? 4'b0100 : 4'b0000);
    end
    brk_valid = 1'b0; pwr_ack = 1'b0;

    // R13: runtime threshold rewrite demotes C10 to C8
    ltr_val = 8'd255;
    wr(3'd7, 8'd200);
    chk("R13", "pkg_state", int'(pkg_state), 7);
    ltr_val = 8'd150;
    tick(); chk("R13", "pkg_state", int'(pkg_state), 8);
    tick(); chk("R13", "pkg_state", int'(pkg_state), 1);
    tick(); chk_outs("R13", 8, 1'b1, 1'b0, '0);
    pwr_ack = 1'b1;
    tick(); chk_outs("R13", 6, 1'b0, 1'b0, '0);
    pwr_ack = 1'b0;

    // R1: reset from a deep state
    rst = 1'b1;
    tick(); chk_outs("R1", 0, 1'b0, 1'b0, '0);
    rst = 1'b0;

    // R1: thresholds back to zero so any tolerance permits C10
    ltr_val = 8'd0;
    tick(); chk("R1", "pkg_state", int'(pkg_state), 1);
    tick(); chk("R1", "pkg_state", int'(pkg_state), 8);
    pwr_ack = 1'b1;
    tick(); chk_outs("R1", 7, 1'b0, 1'b0, '0);
    pwr_ack = 1'b0;

    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule